// File: doc/BRIEF.md
# Table-Call Micro-Op Expander

This decode-stage block takes a compact table-call instruction and cracks it into three simple micro-operations. The instruction names a small unsigned table index and two source registers. The block first copies the two sources into fixed argument registers. It then issues a jump-and-link to a runtime-table entry. The address of that entry is a dedicated base register plus the index scaled to four-byte entries. No instruction field names the base. It comes from a special-register input that the block samples when it accepts the instruction.

Any other instruction passes through as one unchanged micro-op. Instructions arrive on a valid/ready input and leave on a registered valid/ready micro-op stream. A synchronous flush drops a partly emitted sequence and returns the block to idle. The register file, branch execution and fetch redirection belong to the surrounding pipeline.

Top module: `tce_expander`

## Requirements
- R1: While reset is high and on the first cycle after it, `uop_valid_o` is 0 and `in_ready_o` is 1.
- R2: An instruction is a table call when bits [6:0] equal the parameter `TCALL_OPCODE` (default 7'h0B). Its table index is bits [11:7], its first source is bits [19:15] and its second source is bits [24:20]. The first micro-op of a table call has kind MOVE (code 1), destination 10 and source equal to the first source field.
- R3: The second micro-op of a table call has kind MOVE (code 1), destination 11 and source equal to the second source field.
- R4: The third micro-op has kind JAL (code 2) and destination 1. Its target is the base input sampled at acceptance plus four times the index, modulo 2^32. Its source field is 0. Later changes of the base input have no effect on it.
- R5: Micro-ops of a table call are emitted in the order R2, R3, R4 with no gap. A new micro-op is presented in the cycle after the previous one is handed off.
- R6: While `uop_valid_o` is 1 and `uop_ready_i` is 0, every micro-op output stays unchanged on the next cycle.
- R7: `in_ready_o` is 0 until the last micro-op of a table call is being handed off. It is 1 in the cycle that hands off that last micro-op.
- R8: Any other instruction yields exactly one micro-op of kind PASS (code 0) with `uop_inst_o` equal to the instruction and the register and target fields 0. On a MOVE or JAL micro-op, `uop_inst_o` and any unused field are 0.
- R9: A cycle with `flush_i` high leaves `uop_valid_o` at 0 and `in_ready_o` at 1 on the next cycle. No remaining micro-op of the dropped sequence appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Drop any sequence in progress |
| in_valid_i | input | 1 | Instruction valid |
| in_ready_o | output | 1 | Block can accept an instruction |
| in_inst_i | input | 32 | Instruction word |
| rtt_base_i | input | XLEN | Runtime-table base special register |
| uop_valid_o | output | 1 | Micro-op valid |
| uop_ready_i | input | 1 | Downstream takes the micro-op |
| uop_kind_o | output | 2 | 0 PASS, 1 MOVE, 2 JAL |
| uop_rd_o | output | 5 | Destination register |
| uop_rs_o | output | 5 | Source register of a MOVE |
| uop_target_o | output | XLEN | Jump target of a JAL |
| uop_inst_o | output | 32 | Raw instruction of a PASS |

## Verification
The hardest cases to reach are back-pressure and flush in the middle of an expansion. Both depend on where downstream stalls fall relative to the three-step sequence. The bench sweeps all 32 table indices and gives each one a different stall pattern, so that holds land on every step. It also changes the base input right after acceptance. Flush is applied after zero, one and two micro-ops have been handed off, and a pass-through instruction follows each flush to show that no stale micro-op leaks out.

// File: rtl/tce_pkg.sv
package tce_pkg;
  typedef enum logic [1:0] {
    UOP_PASS = 2'd0,
    UOP_MOVE = 2'd1,
    UOP_JAL  = 2'd2
  } uop_kind_e;

  localparam int ILEN   = 32;
  localparam int REG_W  = 5;
  localparam int IDX_W  = 5;

  localparam logic [REG_W-1:0] ARG0_REG = 5'd10;
  localparam logic [REG_W-1:0] ARG1_REG = 5'd11;
  localparam logic [REG_W-1:0] LINK_REG = 5'd1;
endpackage

// File: rtl/tce_decode.sv
module tce_decode
  import tce_pkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          ENTRY_SHIFT  = 2,
  parameter logic [6:0]  TCALL_OPCODE = 7'h0B
) (
  input  logic [ILEN-1:0]  inst_i,
  input  logic [XLEN-1:0]  base_i,
  output logic             is_tcall_o,
  output logic [REG_W-1:0] src_a_o,
  output logic [REG_W-1:0] src_b_o,
  output logic [XLEN-1:0]  target_o
);
  logic [IDX_W-1:0] slot;
  logic [XLEN-1:0]  offset;

  always_comb begin
    is_tcall_o = (inst_i[6:0] == TCALL_OPCODE);
    slot       = inst_i[11:7];
    src_a_o    = inst_i[19:15];
    src_b_o    = inst_i[24:20];
    offset     = XLEN'(slot) << ENTRY_SHIFT;
    target_o   = base_i + offset;
  end
endmodule

// File: rtl/tce_seq.sv
module tce_seq
  import tce_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [ILEN-1:0]  inst_i,
  input  logic             is_tcall_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic [XLEN-1:0]  target_i,
  output logic             uop_valid_o,
  input  logic             uop_ready_i,
  output uop_kind_e        uop_kind_o,
  output logic [REG_W-1:0] uop_rd_o,
  output logic [REG_W-1:0] uop_rs_o,
  output logic [XLEN-1:0]  uop_target_o,
  output logic [ILEN-1:0]  uop_inst_o
);
  logic             busy;
  logic             at_last;
  logic [REG_W-1:0] held_src_b;
  logic [XLEN-1:0]  held_target;
  logic             slot_free;

  assign slot_free  = !uop_valid_o || uop_ready_i;
  assign in_ready_o = !busy && slot_free;

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      busy         <= 1'b0;
      at_last      <= 1'b0;
      held_src_b   <= '0;
      held_target  <= '0;
      uop_valid_o  <= 1'b0;
      uop_kind_o   <= UOP_PASS;
      uop_rd_o     <= '0;
      uop_rs_o     <= '0;
      uop_target_o <= '0;
      uop_inst_o   <= '0;
    end else if (slot_free) begin
      if (busy) begin
        uop_valid_o <= 1'b1;
        uop_kind_o  <= at_last ? UOP_JAL : UOP_MOVE;
        if (!at_last) begin
          uop_rd_o     <= ARG1_REG;
          uop_rs_o     <= held_src_b;
          uop_target_o <= '0;
          at_last      <= 1'b1;
        end else begin
          uop_rd_o     <= LINK_REG;
          uop_rs_o     <= '0;
          uop_target_o <= held_target;
          at_last      <= 1'b0;
          busy         <= 1'b0;
        end
        uop_inst_o <= '0;
      end else if (in_valid_i) begin
        uop_valid_o  <= 1'b1;
        uop_target_o <= '0;
        if (is_tcall_i) begin
          uop_kind_o  <= UOP_MOVE;
          uop_rd_o    <= ARG0_REG;
          uop_rs_o    <= src_a_i;
          uop_inst_o  <= '0;
          held_src_b  <= src_b_i;
          held_target <= target_i;
          busy        <= 1'b1;
          at_last     <= 1'b0;
        end else begin
          uop_kind_o <= UOP_PASS;
          uop_rd_o   <= '0;
          uop_rs_o   <= '0;
          uop_inst_o <= inst_i;
        end
      end else begin
        uop_valid_o <= 1'b0;
      end
    end
  end

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (uop_valid_o && !uop_ready_i && !flush_i) |=>
      (uop_valid_o && $stable(uop_kind_o) && $stable(uop_rd_o) &&
       $stable(uop_rs_o) && $stable(uop_target_o) && $stable(uop_inst_o)));

  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready_o);

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (!uop_valid_o && in_ready_o));

  a_r3_second_move: assert property (@(posedge clk) disable iff (rst)
    (uop_valid_o && uop_ready_i && !flush_i && uop_kind_o == UOP_MOVE &&
     uop_rd_o == ARG0_REG) |=>
      (uop_valid_o && uop_kind_o == UOP_MOVE && uop_rd_o == ARG1_REG));

  a_r4_link_call: assert property (@(posedge clk) disable iff (rst)
    (uop_valid_o && uop_ready_i && !flush_i && uop_kind_o == UOP_MOVE &&
     uop_rd_o == ARG1_REG) |=>
      (uop_valid_o && uop_kind_o == UOP_JAL && uop_rd_o == LINK_REG));
endmodule

// File: rtl/tce_expander.sv
module tce_expander
  import tce_pkg::*;
#(
  parameter int         XLEN         = 32,
  parameter int         ENTRY_SHIFT  = 2,
  parameter logic [6:0] TCALL_OPCODE = 7'h0B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [ILEN-1:0]  in_inst_i,
  input  logic [XLEN-1:0]  rtt_base_i,
  output logic             uop_valid_o,
  input  logic             uop_ready_i,
  output logic [1:0]       uop_kind_o,
  output logic [REG_W-1:0] uop_rd_o,
  output logic [REG_W-1:0] uop_rs_o,
  output logic [XLEN-1:0]  uop_target_o,
  output logic [ILEN-1:0]  uop_inst_o
);
  logic             dec_tcall;
  logic [REG_W-1:0] dec_src_a;
  logic [REG_W-1:0] dec_src_b;
  logic [XLEN-1:0]  dec_target;
  uop_kind_e        kind;

  tce_decode #(
    .XLEN(XLEN), .ENTRY_SHIFT(ENTRY_SHIFT), .TCALL_OPCODE(TCALL_OPCODE)
  ) u_decode (
    .inst_i(in_inst_i), .base_i(rtt_base_i), .is_tcall_o(dec_tcall),
    .src_a_o(dec_src_a), .src_b_o(dec_src_b), .target_o(dec_target)
  );

  tce_seq #(.XLEN(XLEN)) u_seq (
    .clk(clk), .rst(rst), .flush_i(flush_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .inst_i(in_inst_i), .is_tcall_i(dec_tcall),
    .src_a_i(dec_src_a), .src_b_i(dec_src_b), .target_i(dec_target),
    .uop_valid_o(uop_valid_o), .uop_ready_i(uop_ready_i),
    .uop_kind_o(kind), .uop_rd_o(uop_rd_o), .uop_rs_o(uop_rs_o),
    .uop_target_o(uop_target_o), .uop_inst_o(uop_inst_o)
  );

  assign uop_kind_o = kind;
endmodule

// File: tb/test_tce_expander.sv
`timescale 1ns/1ps
module test_tce_expander;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_inst_i = '0;
  logic [31:0] rtt_base_i = '0;
  logic        uop_valid_o;
  logic        uop_ready_i = 1'b0;
  logic [1:0]  uop_kind_o;
  logic [4:0]  uop_rd_o;
  logic [4:0]  uop_rs_o;
  logic [31:0] uop_target_o;
  logic [31:0] uop_inst_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tce_expander i_tce_expander (
    .clk(clk), .rst(rst), .flush_i(flush_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_inst_i(in_inst_i), .rtt_base_i(rtt_base_i),
    .uop_valid_o(uop_valid_o), .uop_ready_i(uop_ready_i),
    .uop_kind_o(uop_kind_o), .uop_rd_o(uop_rd_o), .uop_rs_o(uop_rs_o),
    .uop_target_o(uop_target_o), .uop_inst_o(uop_inst_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_uop(input string req, input logic [1:0] k,
                         input logic [4:0] rd, input logic [4:0] rs,
                         input logic [31:0] tg, input logic [31:0] ins);
    chk(uop_kind_o == k, req, "kind", 32'(uop_kind_o), 32'(k));
    chk(uop_rd_o == rd, req, "rd", 32'(uop_rd_o), 32'(rd));
    chk(uop_rs_o == rs, req, "rs", 32'(uop_rs_o), 32'(rs));
    chk(uop_target_o == tg, req, "target", uop_target_o, tg);
    chk(uop_inst_o == ins, req, "inst", uop_inst_o, ins);
  endtask

  // Accept one instruction; returns at the negedge after the accepting edge.
  task automatic accept(input logic [31:0] inst, input logic [31:0] base);
    @(negedge clk);
    in_valid_i = 1'b1; in_inst_i = inst; rtt_base_i = base; uop_ready_i = 1'b0;
    #1;
    chk(in_ready_o == 1'b1, "R7", "idle ready", 32'(in_ready_o), 32'd1);
    @(negedge clk);
    in_valid_i = 1'b0; in_inst_i = 32'hDEAD_BEEF; rtt_base_i = ~base;
  endtask

  task automatic do_inst(input logic [31:0] inst, input logic [31:0] base,
                         input int pat);
    logic [1:0]  ek [3];
    logic [4:0]  erd [3];
    logic [4:0]  ers [3];
    logic [31:0] etg [3];
    logic [31:0] ein [3];
    int nexp;
    int got = 0;
    bit held = 0;
    logic [1:0]  hk; logic [4:0] hrd, hrs; logic [31:0] htg, hin;
    if (inst[6:0] == 7'h0B) begin
      nexp = 3;
      ek[0] = 2'd1; erd[0] = 5'd10; ers[0] = inst[19:15]; etg[0] = 0; ein[0] = 0;
      ek[1] = 2'd1; erd[1] = 5'd11; ers[1] = inst[24:20]; etg[1] = 0; ein[1] = 0;
      ek[2] = 2'd2; erd[2] = 5'd1;  ers[2] = 5'd0;
      etg[2] = base + 32'(inst[11:7]) * 32'd4; ein[2] = 0;
    end else begin
      nexp = 1;
      ek[0] = 2'd0; erd[0] = 0; ers[0] = 0; etg[0] = 0; ein[0] = inst;
    end
    accept(inst, base);
    for (int cyc = 0; cyc < 40 && got < nexp; cyc++) begin
      uop_ready_i = (cyc >= 8) || (((pat >> cyc) & 1) != 0);
      #1;
      chk(uop_valid_o == 1'b1, "R5", "valid without gap", 32'(uop_valid_o), 32'd1);
      if (held) begin
        chk(uop_kind_o == hk && uop_rd_o == hrd && uop_rs_o == hrs &&
            uop_target_o == htg && uop_inst_o == hin, "R6", "held stable",
            uop_target_o, htg);
      end
      if (uop_valid_o && uop_ready_i) begin
        if (nexp == 1) chk_uop("R8", ek[got], erd[got], ers[got], etg[got], ein[got]);
        else if (got == 0) chk_uop("R2", ek[got], erd[got], ers[got], etg[got], ein[got]);
        else if (got == 1) chk_uop("R3", ek[got], erd[got], ers[got], etg[got], ein[got]);
        else chk_uop("R4", ek[got], erd[got], ers[got], etg[got], ein[got]);
        if (got < nexp - 1)
          chk(in_ready_o == 1'b0, "R7", "busy not ready", 32'(in_ready_o), 32'd0);
        else
          chk(in_ready_o == 1'b1, "R7", "ready on last", 32'(in_ready_o), 32'd1);
        got++;
        held = 0;
      end else begin
        held = 1;
        hk = uop_kind_o; hrd = uop_rd_o; hrs = uop_rs_o;
        htg = uop_target_o; hin = uop_inst_o;
      end
      @(negedge clk);
    end
    chk(got == nexp, "R5", "uop count", 32'(got), 32'(nexp));
    uop_ready_i = 1'b0;
    #1;
    chk(uop_valid_o == 1'b0, "R8", "no extra uop", 32'(uop_valid_o), 32'd0);
  endtask

  task automatic do_flush(input logic [31:0] inst, input logic [31:0] base,
                          input int k);
    accept(inst, base);
    for (int i = 0; i < k; i++) begin
      uop_ready_i = 1'b1;
      @(negedge clk);
    end
    uop_ready_i = 1'b0; flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    #1;
    chk(uop_valid_o == 1'b0, "R9", "valid after flush", 32'(uop_valid_o), 32'd0);
    chk(in_ready_o == 1'b1, "R9", "ready after flush", 32'(in_ready_o), 32'd1);
    // a following pass-through must come out alone, no stale move or call
    do_inst(32'h0000_1033 | (32'(k) << 20), base, 32'hFF);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(uop_valid_o == 1'b0, "R1", "valid in reset", 32'(uop_valid_o), 32'd0);
    chk(in_ready_o == 1'b1, "R1", "ready in reset", 32'(in_ready_o), 32'd1);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(uop_valid_o == 1'b0, "R1", "valid after reset", 32'(uop_valid_o), 32'd0);
    chk(in_ready_o == 1'b1, "R1", "ready after reset", 32'(in_ready_o), 32'd1);

    // all table indices, varied sources, bases and stall patterns
    for (int idx = 0; idx < 32; idx++) begin
      logic [4:0] ra = 5'(idx) ^ 5'h15;
      logic [4:0] rb = ~5'(idx);
      logic [31:0] base = 32'h4000_0000 + 32'(idx) * 32'h1234;
      do_inst({7'h0, rb, ra, 3'b000, 5'(idx), 7'h0B}, base, (idx * 37 + 11) & 8'hFF);
    end
    // target wraps past the top of the address space
    do_inst({7'h0, 5'd3, 5'd4, 3'b000, 5'd31, 7'h0B}, 32'hFFFF_FFF0, 8'h5A);
    do_inst({7'h7F, 5'd0, 5'd31, 3'b111, 5'd27, 7'h0B}, 32'h0000_1000, 8'h00);

    // every other opcode passes through
    for (int op = 0; op < 128; op++) begin
      if (op != 8'h0B)
        do_inst({25'(op * 32'h1_9E37 + 7), 7'(op)}, 32'h1111_2222, op & 8'hFF);
    end

    for (int k = 0; k < 3; k++)
      do_flush({7'h0, 5'd7, 5'd9, 3'b000, 5'(k + 4), 7'h0B}, 32'h2000_0000, k);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule